// File: doc/BRIEF.md
# Seven-Thread Four-Slot Instruction Issue Arbiter

This block sits between the thread state of a multithreaded SIMD execution unit and its four issue pipes. Each of seven hardware threads offers at most one ready instruction together with a 2-bit class tag and a payload. Every cycle the arbiter matches threads to four typed issue slots: two floating-point slots, one branch slot and one message-send slot. It issues up to four instructions per cycle, never more than one per thread and never more than one per slot.

Fairness comes from rotating priority. Each instruction class keeps its own pointer. A class grants the first requesting threads found at or after its pointer. After any cycle with a grant in that class, the pointer moves to the thread just after the last thread granted. An instruction that is not granted stays pending at the thread, unchanged, until it is accepted.

Both edges of the block use a valid/ready handshake. On the thread side, `thr_valid` with `thr_class` and `thr_payload` form the offer, and `thr_accept` is the ready that completes it. A thread must hold its offer stable until `thr_accept` is high at a clock edge. On the slot side, each pipe drives `slot_ready`. The arbiter raises `slot_valid` only in a cycle where that slot's `slot_ready` is high, so every `slot_valid` is a completed transfer. A pipe holding `slot_ready` low back-pressures only its own slot. All grants are combinational from the current inputs and the pointer registers.

Top module: `issue_arbiter`

## Requirements
- R1: After reset every class pointer is at thread 0. With no thread valid, all `slot_valid` and `thr_accept` bits are 0. With all threads offering floating-point work and all slots ready, slot 0 carries thread 0 and slot 1 carries thread 1.
- R2: Class codes are 0 for floating point, 1 for branch, 2 for message send, and 3 for reserved. Class 0 issues only on slots 0 and 1. Class 1 issues only on slot 2. Class 2 issues only on slot 3. Class 3 is never issued.
- R3: In one cycle no thread appears on more than one slot. `thr_accept[t]` is high exactly when some valid slot carries thread `t`.
- R4: A slot whose `slot_ready` is low has `slot_valid` low in that cycle.
- R5: If only one floating-point instruction is issued and slot 0 is ready, it goes to slot 0. Slot 1 carries a thread only when slot 0 also carries one or slot 0 is not ready.
- R6: Within a class, grants go to the requesting threads in rotating order, starting from that class's pointer. After a cycle with a grant in that class, the pointer moves to the thread after the last thread granted. Otherwise the pointer is unchanged.
- R7: `slot_tid` and `slot_payload` of a valid slot equal the index and payload of the thread granted to it.
- R8: A thread that stays valid, and whose class has a ready slot, is accepted within 7 cycles.
- R9: A thread not granted sees `thr_accept` low and may keep its offer unchanged. The offer is granted later under the same rules.
- R10: The block is work conserving. Each class issues as many instructions as the smaller of its ready slot count and its requesting thread count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_valid | input | 7 | Per-thread instruction offered |
| thr_class | input | 7x2 | Per-thread class code (0 FP, 1 branch, 2 send, 3 reserved) |
| thr_payload | input | 7x32 | Per-thread instruction payload |
| thr_accept | output | 7 | Per-thread grant strobe (ready of the thread handshake) |
| slot_ready | input | 4 | Per-slot pipe can take an instruction (0,1 FP; 2 branch; 3 send) |
| slot_valid | output | 4 | Per-slot instruction issued this cycle |
| slot_tid | output | 4x3 | Thread index issued on each slot |
| slot_payload | output | 4x32 | Payload issued on each slot |

## Verification
A corrupted rotation pointer shows at the ports in the next cycle that has two or more competing requesters in that class: the wrong thread index appears on a slot, and the wrong `thr_accept` bit rises with it. A pointer that stops moving, or skips a thread, shows up as a thread left waiting longer than seven ready cycles. A wrong slot-selection or routing decision is visible in the same cycle, as a slot valid while not ready, a thread on two slots, or an idle slot while a matching thread waits. The bench runs a reference model of the pointers alongside the design and compares every slot and accept bit in every cycle, so a divergence is reported in the cycle it first reaches the ports.

// File: rtl/issue_arb_pkg.sv
package issue_arb_pkg;

  typedef enum logic [1:0] {
    CLS_FP   = 2'd0,
    CLS_BR   = 2'd1,
    CLS_SEND = 2'd2,
    CLS_RSVD = 2'd3
  } iclass_e;

  localparam int NUM_SLOTS   = 4;
  localparam int NUM_CLASSES = 3;
  localparam int SLOT_FP0    = 0;
  localparam int SLOT_FP1    = 1;
  localparam int SLOT_BR     = 2;
  localparam int SLOT_SEND   = 3;

  // number of issue lanes owned by a class
  function automatic int lanes_of(input int cls);
    return (cls == int'(CLS_FP)) ? 2 : 1;
  endfunction

  // first slot index owned by a class
  function automatic int base_of(input int cls);
    return (cls == int'(CLS_FP)) ? SLOT_FP0 : cls + 1;
  endfunction

  // class code served by a slot
  function automatic logic [1:0] class_of_slot(input int slot);
    if (slot == SLOT_FP0 || slot == SLOT_FP1) return CLS_FP;
    if (slot == SLOT_BR) return CLS_BR;
    return CLS_SEND;
  endfunction

endpackage

// File: rtl/issue_rr_pick.sv
// Rotating first-set finder: returns the first set request at or after start.
module issue_rr_pick #(
  parameter int N  = 7,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] start,
  output logic          found,
  output logic [TW-1:0] idx
);

  logic [TW:0] k;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    k     = '0;
    for (int i = 0; i < N; i++) begin
      k = {1'b0, start} + (TW+1)'(i);
      if (k >= (TW+1)'(N)) k = k - (TW+1)'(N);
      if (!found && req[k[TW-1:0]]) begin
        found = 1'b1;
        idx   = k[TW-1:0];
      end
    end
  end

endmodule

// File: rtl/issue_class_arb.sv
// One instruction class: rotating pointer, one or two issue lanes.
module issue_class_arb #(
  parameter int N  = 7,
  parameter int TW = $clog2(N),
  parameter int NG = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          req,
  input  logic [NG-1:0]         lane_rdy,
  output logic [NG-1:0]         lane_vld,
  output logic [NG-1:0][TW-1:0] lane_tid,
  output logic [N-1:0]          gnt
);

  logic [TW-1:0] ptr_q, ptr_d;
  logic          f0;
  logic [TW-1:0] i0;
  logic [TW-1:0] last_idx;
  logic          any_gnt;

  issue_rr_pick #(.N(N), .TW(TW)) u_pick0 (
    .req(req), .start(ptr_q), .found(f0), .idx(i0)
  );

  generate
    if (NG == 2) begin : g_dual
      logic [N-1:0]  req1;
      logic          f1;
      logic [TW-1:0] i1;

      always_comb begin
        req1 = req;
        if (f0) req1[i0] = 1'b0;
      end

      issue_rr_pick #(.N(N), .TW(TW)) u_pick1 (
        .req(req1), .start(ptr_q), .found(f1), .idx(i1)
      );

      // lower-numbered ready lane takes the first pick
      always_comb begin
        lane_vld = '0;
        lane_tid = '0;
        last_idx = i0;
        if (lane_rdy[0] && lane_rdy[1]) begin
          lane_vld[0] = f0;
          lane_tid[0] = f0 ? i0 : '0;
          lane_vld[1] = f1;
          lane_tid[1] = f1 ? i1 : '0;
          if (f1) last_idx = i1;
        end else if (lane_rdy[0]) begin
          lane_vld[0] = f0;
          lane_tid[0] = f0 ? i0 : '0;
        end else if (lane_rdy[1]) begin
          lane_vld[1] = f0;
          lane_tid[1] = f0 ? i0 : '0;
        end
      end

      // R5: second lane only used when the first is used or unavailable
      a_r5_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        lane_vld[1] |-> (lane_vld[0] || !lane_rdy[0]));
    end else begin : g_single
      always_comb begin
        lane_vld[0] = lane_rdy[0] && f0;
        lane_tid[0] = (lane_rdy[0] && f0) ? i0 : '0;
        last_idx    = i0;
      end
    end
  endgenerate

  assign any_gnt = |lane_vld;

  always_comb begin
    gnt = '0;
    for (int l = 0; l < NG; l++)
      if (lane_vld[l]) gnt[lane_tid[l]] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (any_gnt) ptr_d = (last_idx == TW'(N-1)) ? '0 : last_idx + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R4: a lane never issues while its pipe is not ready
  a_r4_lane_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld & ~lane_rdy) == '0);

  // R10: some issue happens whenever a lane is ready and a thread requests
  a_r10_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lane_rdy) && (|req)) |-> (|lane_vld));

  // R6: the thread at the pointer wins whenever the class issues and it requests
  a_r6_pointer_first: assert property (@(posedge clk) disable iff (!rst_n)
    (any_gnt && req[ptr_q]) |-> gnt[ptr_q]);

  // R3: grants never exceed requests
  a_r3_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import issue_arb_pkg::*;
#(
  parameter  int NUM_THREADS = 7,
  parameter  int PAYLOAD_W   = 32,
  localparam int TID_W       = $clog2(NUM_THREADS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_THREADS-1:0]                thr_valid,
  input  logic [NUM_THREADS-1:0][1:0]           thr_class,
  input  logic [NUM_THREADS-1:0][PAYLOAD_W-1:0] thr_payload,
  output logic [NUM_THREADS-1:0]                thr_accept,
  input  logic [3:0]                            slot_ready,
  output logic [3:0]                            slot_valid,
  output logic [3:0][TID_W-1:0]                 slot_tid,
  output logic [3:0][PAYLOAD_W-1:0]             slot_payload
);

  localparam int N = NUM_THREADS;

  logic [NUM_CLASSES-1:0][N-1:0] cls_gnt;

  generate
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      localparam int NG   = lanes_of(c);
      localparam int BASE = base_of(c);
      logic [N-1:0] req;

      always_comb begin
        for (int t = 0; t < N; t++)
          req[t] = thr_valid[t] && (thr_class[t] == 2'(c));
      end

      issue_class_arb #(.N(N), .TW(TID_W), .NG(NG)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .lane_rdy (slot_ready[BASE +: NG]),
        .lane_vld (slot_valid[BASE +: NG]),
        .lane_tid (slot_tid[BASE +: NG]),
        .gnt      (cls_gnt[c])
      );
    end
  endgenerate

  always_comb begin
    thr_accept = '0;
    for (int c = 0; c < NUM_CLASSES; c++) thr_accept = thr_accept | cls_gnt[c];
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++)
      slot_payload[s] = slot_valid[s] ? thr_payload[slot_tid[s]] : '0;
  end

  // ---------------------------------------------------------------- checks
  logic [N-1:0] avail;
  logic [N-1:0][TID_W:0] wait_q;

  always_comb begin
    for (int t = 0; t < N; t++) begin
      unique case (thr_class[t])
        CLS_FP:   avail[t] = slot_ready[SLOT_FP0] || slot_ready[SLOT_FP1];
        CLS_BR:   avail[t] = slot_ready[SLOT_BR];
        CLS_SEND: avail[t] = slot_ready[SLOT_SEND];
        default:  avail[t] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int t = 0; t < N; t++) begin
      if (!rst_n || !thr_valid[t] || thr_accept[t] || !avail[t])
        wait_q[t] <= '0;
      else if (wait_q[t] != '1)
        wait_q[t] <= wait_q[t] + 1'b1;
    end
  end

  generate
    for (genvar t = 0; t < N; t++) begin : g_thr_chk
      // R8: no thread waits N ready cycles
      a_r8_no_starve: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wait_q[t]) < N);
    end
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
      // R2: a slot only carries an offered instruction of its own class
      a_r2_class_route: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[s] |-> (thr_valid[slot_tid[s]] &&
                           thr_class[slot_tid[s]] == class_of_slot(s)));
      // R7: accept strobe of the carried thread is raised
      a_r7_tid_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid[s] |-> thr_accept[slot_tid[s]]);
      for (genvar u = s + 1; u < NUM_SLOTS; u++) begin : g_pair
        // R3: no thread on two slots
        a_r3_distinct_tid: assert property (@(posedge clk) disable iff (!rst_n)
          (slot_valid[s] && slot_valid[u]) |-> (slot_tid[s] != slot_tid[u]));
      end
    end
  endgenerate

  // R9: one accept per issued slot
  a_r9_accept_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(thr_accept) == $countones(slot_valid));

endmodule

// File: tb/issue_arbiter_bench.sv
module issue_arbiter_bench;
  localparam int N  = 7;
  localparam int W  = 32;
  localparam int TW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         thr_valid;
  logic [N-1:0][1:0]    thr_class;
  logic [N-1:0][W-1:0]  thr_payload;
  logic [N-1:0]         thr_accept;
  logic [3:0]           slot_ready;
  logic [3:0]           slot_valid;
  logic [3:0][TW-1:0]   slot_tid;
  logic [3:0][W-1:0]    slot_payload;

  issue_arbiter #(.NUM_THREADS(N), .PAYLOAD_W(W)) u_issue_arbiter (
    .clk(clk), .rst_n(rst_n), .thr_valid(thr_valid), .thr_class(thr_class),
    .thr_payload(thr_payload), .thr_accept(thr_accept), .slot_ready(slot_ready),
    .slot_valid(slot_valid), .slot_tid(slot_tid), .slot_payload(slot_payload)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int tv[N], tc[N], tp[N];
  int mptr[3], mnext[3];
  int ev[4], et[4], eacc[N];
  int wt[N], max_wait;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int t = 0; t < N; t++) begin
      thr_valid[t]   = (tv[t] != 0);
      thr_class[t]   = 2'(tc[t]);
      thr_payload[t] = W'(tp[t]);
    end
  endtask

  // reference: rotating pick per class from the model pointers
  function automatic void model();
    for (int s = 0; s < 4; s++) begin ev[s] = 0; et[s] = 0; end
    for (int t = 0; t < N; t++) eacc[t] = 0;
    for (int c = 0; c < 3; c++) begin
      int p[2];
      int np = 0;
      int last = -1;
      p[0] = 0; p[1] = 0;
      for (int i = 0; i < N; i++) begin
        int t = (mptr[c] + i) % N;
        if (tv[t] != 0 && tc[t] == c && np < 2) begin p[np] = t; np++; end
      end
      if (c == 0) begin
        if (slot_ready[0] && slot_ready[1]) begin
          if (np >= 1) begin ev[0] = 1; et[0] = p[0]; last = p[0]; end
          if (np >= 2) begin ev[1] = 1; et[1] = p[1]; last = p[1]; end
        end else if (slot_ready[0]) begin
          if (np >= 1) begin ev[0] = 1; et[0] = p[0]; last = p[0]; end
        end else if (slot_ready[1]) begin
          if (np >= 1) begin ev[1] = 1; et[1] = p[0]; last = p[0]; end
        end
      end else if (slot_ready[c+1] && np >= 1) begin
        ev[c+1] = 1; et[c+1] = p[0]; last = p[0];
      end
      mnext[c] = (last >= 0) ? (last + 1) % N : mptr[c];
    end
    for (int s = 0; s < 4; s++) if (ev[s] != 0) eacc[et[s]] = 1;
  endfunction

  // one cycle: inputs already driven after negedge; compare, then clock
  task automatic step(input string rq);
    #5;
    model();
    for (int s = 0; s < 4; s++) begin
      bit ok;
      ok = (int'(slot_valid[s]) == ev[s]);
      if (ev[s] != 0) ok = ok && int'(slot_tid[s]) == et[s] &&
                           slot_payload[s] == W'(tp[et[s]]);
      chk(ok, rq, $sformatf("slot%0d valid/tid", s),
          slot_valid[s] ? int'(slot_tid[s]) : -1, ev[s] != 0 ? et[s] : -1);
    end
    begin
      int acc_exp = 0;
      for (int t = 0; t < N; t++) acc_exp |= eacc[t] << t;
      chk(int'(thr_accept) == acc_exp, "R3 R9", "accept", thr_accept, acc_exp);
    end
    @(posedge clk);
    for (int c = 0; c < 3; c++) mptr[c] = mnext[c];
    @(negedge clk);
  endtask

  task automatic set_all(input int v, input int cls);
    for (int t = 0; t < N; t++) begin tv[t] = v; tc[t] = cls; tp[t] = 'h100 + t * 17; end
  endtask

  initial begin
    for (int c = 0; c < 3; c++) mptr[c] = 0;
    set_all(0, 0);
    slot_ready = 4'hF;
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then first FP picks start at thread 0
    #5;
    chk(slot_valid == 4'b0 && thr_accept == '0, "R1", "idle outputs",
        {slot_valid, thr_accept}, 0);
    @(negedge clk);
    set_all(1, 0); drive(); #5;
    chk(slot_valid[0] && slot_tid[0] == 0, "R1", "slot0 tid", slot_tid[0], 0);
    chk(slot_valid[1] && slot_tid[1] == 1, "R1", "slot1 tid", slot_tid[1], 1);
    @(negedge clk);
    // pointer of FP class is now at 2 after that cycle; model mirrors it
    mptr[0] = 2;

    // R2: reserved class never issues; single branch and send route correctly
    set_all(1, 3); drive(); step("R2");
    tc[2] = 1; tc[5] = 2; drive(); step("R2");
    set_all(1, 2); tc[0] = 1; drive(); step("R2");

    // R4: no ready pipe, nothing issues
    set_all(1, 0); tc[3] = 1; tc[4] = 2; slot_ready = 4'h0; drive(); step("R4");
    #5; chk(slot_valid == 4'b0, "R4", "valid while not ready", slot_valid, 0);
    @(negedge clk);

    // R5: one FP lane ready
    set_all(1, 0); slot_ready = 4'b1110; drive(); step("R5");
    slot_ready = 4'b1101; drive(); step("R5");
    set_all(0, 0); tv[6] = 1; slot_ready = 4'b1111; drive(); step("R5");

    // R7: distinct payloads on all four slots
    set_all(1, 3); tc[1] = 0; tc[3] = 0; tc[4] = 1; tc[6] = 2;
    for (int t = 0; t < N; t++) tp[t] = 32'hA5000000 + t * 32'h1111;
    drive(); step("R7");

    // R10: sweep all ready patterns over all valid patterns
    for (int r = 0; r < 16; r++) begin
      for (int v = 0; v < (1 << N); v++) begin
        slot_ready = 4'(r);
        for (int t = 0; t < N; t++) begin
          tv[t] = (v >> t) & 1; tc[t] = (t + r) % 3; tp[t] = v * 64 + t;
        end
        drive(); step("R10");
      end
    end

    // R6 R8 R9: held offers, random back-pressure, replacement after accept
    for (int t = 0; t < N; t++) begin
      tv[t] = 1; tc[t] = $urandom_range(2); tp[t] = $urandom; wt[t] = 0;
    end
    max_wait = 0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      for (int s = 0; s < 4; s++) slot_ready[s] = ($urandom_range(9) < 8);
      drive();
      step("R6");
      for (int t = 0; t < N; t++) begin
        bit av;
        av = (tc[t] == 0) ? (slot_ready[0] | slot_ready[1]) :
             (tc[t] == 1) ? slot_ready[2] : slot_ready[3];
        if (eacc[t] != 0) begin
          wt[t] = 0;
          tv[t] = ($urandom_range(7) != 0);
          tc[t] = $urandom_range(3);
          tp[t] = $urandom;
        end else if (tv[t] == 0) begin
          wt[t] = 0;
          tv[t] = 1; tc[t] = $urandom_range(2); tp[t] = $urandom;
        end else if (av && tc[t] != 3) begin
          wt[t]++;
          if (wt[t] > max_wait) max_wait = wt[t];
        end else begin
          wt[t] = 0;
          if (tc[t] == 3) begin tv[t] = 0; end
        end
      end
    end
    chk(max_wait < N, "R8", "longest wait", max_wait, N - 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule